// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block sets the line and frame timing for a display controller. A pixel tick advances a horizontal counter. A completed line advances a scanline counter, which wraps to zero after the last programmed line. Each completed line is checked against the programmed line numbers. These checks drive two interrupt pulses, a vertical blanking window and a frame-start pulse. The block also keeps a field bit that alternates between frames in interlaced operation.

Software programs the block through a simple write port with four registers. A rate bit picks between full-rate pixel timing for monitor modes and half-rate timing for television modes. The status word always shows the current scanline, the blanking flag as vsync, and the field bit.

Top module: `raster_sync_gen`

## Requirements
- R1: While `rst_ni` is low, `status_o`, `irq_o` and `frame_start_o` are all zero. Reset defaults are: line length `H_DEF`, frame length `V_DEF`, interrupt lines 0, blank lines 0, progressive, full rate.
- R2: With the mode register's bit 1 set (full rate), a pixel tick occurs every clock. A line completes after (h_last + 1) ticks, where h_last is bits [9:0] of the timing register (address 0).
- R3: With mode bit 1 clear (half rate), a tick occurs every second clock, so a line lasts 2*(h_last + 1) clocks.
- R4: The scanline in `status_o[9:0]` increases by one per completed line. After reaching v_last (timing register bits [19:10]) it wraps to 0, giving v_last + 1 lines per frame.
- R5: `irq_o[0]` pulses for one clock when a completed line moves the scanline to the value in bits [9:0] of the interrupt register (address 1). The pulse appears in the same cycle that `status_o` shows the new scanline.
- R6: `irq_o[1]` behaves in the same way for bits [19:10] of address 1. Both pulses fire together when both fields hold the same line.
- R7: The vsync flag `status_o[10]` is set when a completed line moves the scanline to the blank-start line (address 2, bits [9:0]). It is cleared when the new scanline equals the blank-end line (bits [19:10]). The end line wins if the two are equal. Otherwise the flag holds its value.
- R8: `frame_start_o` pulses for one clock when a completed line moves the scanline to 0.
- R9: With mode bit 0 set (interlaced), the field bit `status_o[11]` toggles at each frame wrap. With bit 0 clear, it reads 0 from the cycle after the mode takes effect.
- R10: A write to address 0 restarts timing from the write edge. The pixel phase, the horizontal count, the scanline, vsync and the field bit all return to 0, and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 timing, 1 interrupt lines, 2 blank lines, 3 mode |
| wr_data_i | input | 2*CNT_W | Write data |
| irq_o | output | 2 | Scanline-match interrupt pulses |
| frame_start_o | output | 1 | Pulse when the scanline wraps to 0 |
| status_o | output | CNT_W+2 | {field, vsync, scanline} |

## Verification
Every output is registered, so each result appears in the clock cycle after the edge that completes a line. The pulses, vsync, field bit and new scanline all change on that same edge. A timing write takes effect at its own edge. A mode change affects the field bit one edge later. The bench advances a behavioural model at each rising edge, using the same inputs, and compares all outputs at the following falling edge. This puts each comparison exactly one register stage after its cause. Line periods are measured in falling edges from the restarting write to the first scanline change: h_last + 2 at full rate and 2*(h_last + 1) + 1 at half rate.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned NUM_IRQ    = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_TIMING = 2'd0,
    REG_IRQ    = 2'd1,
    REG_BLANK  = 2'd2,
    REG_MODE   = 2'd3
  } reg_addr_e;

  // bit0 interlace, bit1 full-rate pixel tick
  typedef struct packed {
    logic full_rate;
    logic interlace;
  } mode_t;
endpackage

// File: rtl/rsg_cfg_regs.sv
module rsg_cfg_regs
  import rsg_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned H_DEF = 857,
  parameter int unsigned V_DEF = 524
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [REG_ADDR_W-1:0]           wr_addr_i,
  input  logic [2*CNT_W-1:0]              wr_data_i,
  output logic [CNT_W-1:0]                h_last_o,
  output logic [CNT_W-1:0]                v_last_o,
  output logic [NUM_IRQ-1:0][CNT_W-1:0]   irq_line_o,
  output logic [CNT_W-1:0]                blank_start_o,
  output logic [CNT_W-1:0]                blank_end_o,
  output mode_t                           mode_o,
  output logic                            restart_o
);
  logic wr_timing, wr_irq, wr_blank, wr_mode;

  assign wr_timing = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_TIMING);
  assign wr_irq    = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_IRQ);
  assign wr_blank  = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_BLANK);
  assign wr_mode   = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_MODE);
  assign restart_o = wr_timing;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_last_o <= CNT_W'(H_DEF);
      v_last_o <= CNT_W'(V_DEF);
    end else if (wr_timing) begin
      h_last_o <= wr_data_i[CNT_W-1:0];
      v_last_o <= wr_data_i[2*CNT_W-1:CNT_W];
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     irq_line_o[k] <= '0;
      else if (wr_irq) irq_line_o[k] <= wr_data_i[k*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_start_o <= '0;
      blank_end_o   <= '0;
    end else if (wr_blank) begin
      blank_start_o <= wr_data_i[CNT_W-1:0];
      blank_end_o   <= wr_data_i[2*CNT_W-1:CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_o <= '{full_rate: 1'b1, interlace: 1'b0};
    else if (wr_mode) mode_o <= mode_t'(wr_data_i[1:0]);
  end
endmodule

// File: rtl/rsg_pix_tick.sv
module rsg_pix_tick #(
  parameter int unsigned SLOW_DIV = 2,
  localparam int unsigned DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic full_rate_i,
  output logic tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             cnt_top;

  assign cnt_top = (cnt_q == DIV_W'(SLOW_DIV - 1));
  assign tick_o  = full_rate_i || cnt_top;

  // phase runs in both modes; restart realigns it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (cnt_top)   cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rsg_line_timer.sv
module rsg_line_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] h_last_i,
  output logic             line_done_o
);
  logic [CNT_W-1:0] h_q;

  assign line_done_o = tick_i && (h_q == h_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          h_q <= '0;
    else if (restart_i)   h_q <= '0;
    else if (line_done_o) h_q <= '0;
    else if (tick_i)      h_q <= h_q + 1'b1;
  end
endmodule

// File: rtl/rsg_frame_ctrl.sv
module rsg_frame_ctrl
  import rsg_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          restart_i,
  input  logic                          line_done_i,
  input  logic [CNT_W-1:0]              v_last_i,
  input  logic [NUM_IRQ-1:0][CNT_W-1:0] irq_line_i,
  input  logic [CNT_W-1:0]              blank_start_i,
  input  logic [CNT_W-1:0]              blank_end_i,
  input  logic                          interlace_i,
  output logic [CNT_W-1:0]              scanline_o,
  output logic                          blank_o,
  output logic                          field_o,
  output logic [NUM_IRQ-1:0]            irq_o,
  output logic                          frame_o
);
  logic [CNT_W-1:0] scan_nxt;
  logic             wrap;

  assign scan_nxt = (scanline_o == v_last_i) ? '0 : scanline_o + 1'b1;
  assign wrap     = line_done_i && (scan_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scanline_o <= '0;
      blank_o    <= 1'b0;
      field_o    <= 1'b0;
      frame_o    <= 1'b0;
    end else if (restart_i) begin
      scanline_o <= '0;
      blank_o    <= 1'b0;
      field_o    <= 1'b0;
      frame_o    <= 1'b0;
    end else begin
      frame_o <= wrap;
      if (line_done_i) begin
        scanline_o <= scan_nxt;
        // end line takes priority over start line
        if (scan_nxt == blank_end_i)        blank_o <= 1'b0;
        else if (scan_nxt == blank_start_i) blank_o <= 1'b1;
      end
      if (!interlace_i) field_o <= 1'b0;
      else if (wrap)    field_o <= ~field_o;
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        irq_o[k] <= 1'b0;
      else if (restart_i) irq_o[k] <= 1'b0;
      else                irq_o[k] <= line_done_i && (scan_nxt == irq_line_i[k]);
    end
  end
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned H_DEF    = 857,
  parameter int unsigned V_DEF    = 524,
  parameter int unsigned SLOW_DIV = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [2*CNT_W-1:0]    wr_data_i,
  output logic [NUM_IRQ-1:0]    irq_o,
  output logic                  frame_start_o,
  output logic [CNT_W+1:0]      status_o
);
  logic [CNT_W-1:0]              h_last, v_last, blank_start, blank_end, scanline;
  logic [NUM_IRQ-1:0][CNT_W-1:0] irq_line;
  mode_t                         mode;
  logic                          restart, tick, line_done, blank, field, interlace;

  assign interlace = mode.interlace;

  rsg_cfg_regs #(.CNT_W(CNT_W), .H_DEF(H_DEF), .V_DEF(V_DEF)) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .h_last_o(h_last), .v_last_o(v_last), .irq_line_o(irq_line),
    .blank_start_o(blank_start), .blank_end_o(blank_end),
    .mode_o(mode), .restart_o(restart)
  );

  rsg_pix_tick #(.SLOW_DIV(SLOW_DIV)) i_tick (
    .clk_i, .rst_ni, .restart_i(restart), .full_rate_i(mode.full_rate), .tick_o(tick)
  );

  rsg_line_timer #(.CNT_W(CNT_W)) i_line (
    .clk_i, .rst_ni, .restart_i(restart), .tick_i(tick), .h_last_i(h_last),
    .line_done_o(line_done)
  );

  rsg_frame_ctrl #(.CNT_W(CNT_W)) i_frame (
    .clk_i, .rst_ni, .restart_i(restart), .line_done_i(line_done),
    .v_last_i(v_last), .irq_line_i(irq_line), .blank_start_i(blank_start),
    .blank_end_i(blank_end), .interlace_i(interlace),
    .scanline_o(scanline), .blank_o(blank), .field_o(field),
    .irq_o(irq_o), .frame_o(frame_start_o)
  );

  assign status_o = {field, blank, scanline};
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker
  import rsg_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_IRQ-1:0]            irq_i,
  input logic                          frame_i,
  input logic [CNT_W-1:0]              scan_i,
  input logic                          field_i,
  input logic [CNT_W-1:0]              v_last_i,
  input logic [NUM_IRQ-1:0][CNT_W-1:0] irq_line_i,
  input logic                          interlace_i
);
  AST_IRQ0_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[0] |-> (scan_i == irq_line_i[0])); // R5

  AST_IRQ1_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[1] |-> (scan_i == irq_line_i[1])); // R6

  AST_SCAN_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_i <= v_last_i); // R4

  AST_SCAN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i != $past(scan_i)) |-> (scan_i == '0 || scan_i == CNT_W'($past(scan_i) + 1'b1))); // R4

  AST_FRAME_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |-> (scan_i == '0)); // R8

  AST_FIELD_PROGRESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interlace_i |=> !field_i); // R9
endmodule

bind raster_sync_gen rsg_checker #(.CNT_W(CNT_W)) i_rsg_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_o), .frame_i(frame_start_o),
  .scan_i(scanline), .field_i(field), .v_last_i(v_last),
  .irq_line_i(irq_line), .interlace_i(interlace)
);

// File: tb/test_raster_sync_gen.sv
`timescale 1ns/1ps
module test_raster_sync_gen;
  localparam int CNT_W = 10;
  localparam int H0 = 7;
  localparam int V0 = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [2*CNT_W-1:0] data = '0;
  logic [1:0] irq;
  logic frame;
  logic [CNT_W+1:0] status;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int both_seen = 0;

  always #10 clk = ~clk;

  raster_sync_gen #(.CNT_W(CNT_W), .H_DEF(H0), .V_DEF(V0), .SLOW_DIV(2)) i_raster_sync_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data),
    .irq_o(irq), .frame_start_o(frame), .status_o(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int c_h, c_v, c_l0, c_l1, c_bs, c_be, c_il, c_full;
  int m_h, m_scan, m_phase, m_blank, m_field, m_irq0, m_irq1, m_frame;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_h = H0; c_v = V0; c_l0 = 0; c_l1 = 0; c_bs = 0; c_be = 0; c_il = 0; c_full = 1;
      m_h = 0; m_scan = 0; m_phase = 0; m_blank = 0; m_field = 0;
      m_irq0 = 0; m_irq1 = 0; m_frame = 0;
    end else begin
      bit tk, dn;
      tk = (c_full != 0) || (m_phase == 1);
      dn = 0;
      if (we && addr == 2'd0) begin
        c_h = int'(data[9:0]); c_v = int'(data[19:10]);
        m_h = 0; m_scan = 0; m_phase = 0; m_blank = 0; m_field = 0;
        m_irq0 = 0; m_irq1 = 0; m_frame = 0;
      end else begin
        if (tk) begin
          if (m_h == c_h) begin m_h = 0; dn = 1; end
          else m_h = m_h + 1;
        end
        m_phase = 1 - m_phase;
        m_irq0 = 0; m_irq1 = 0; m_frame = 0;
        if (dn) begin
          m_scan = (m_scan == c_v) ? 0 : m_scan + 1;
          m_irq0 = (m_scan == c_l0);
          m_irq1 = (m_scan == c_l1);
          m_frame = (m_scan == 0);
          if (m_scan == c_be) m_blank = 0;
          else if (m_scan == c_bs) m_blank = 1;
        end
        if (c_il == 0) m_field = 0;
        else if (dn && m_scan == 0) m_field = 1 - m_field;
      end
      if (we) begin
        case (addr)
          2'd1: begin c_l0 = int'(data[9:0]); c_l1 = int'(data[19:10]); end
          2'd2: begin c_bs = int'(data[9:0]); c_be = int'(data[19:10]); end
          2'd3: begin c_il = int'(data[0]); c_full = int'(data[1]); end
          default: ;
        endcase
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 scanline", int'(status[9:0]), m_scan);
      chk("R7 vsync", int'(status[10]), m_blank);
      chk("R9 field", int'(status[11]), m_field);
      chk("R5 irq0", int'(irq[0]), m_irq0);
      chk("R6 irq1", int'(irq[1]), m_irq1);
      chk("R8 frame_start", int'(frame), m_frame);
      if (irq == 2'b11) both_seen++;
    end
  end

  task automatic wr(input int a, input logic [2*CNT_W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = 2'(a); data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // restart with new timing and count falling edges until scanline reaches 1
  task automatic load_measure(input int h, input int v, input int exp_n, input string req);
    int n;
    wr(0, {10'(v), 10'(h)});
    chk("R10 restart scanline", int'(status[9:0]), 0);
    chk("R10 restart vsync", int'(status[10]), 0);
    chk("R10 restart field", int'(status[11]), 0);
    n = 1;
    while (status[9:0] != 10'd1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(req, n, exp_n);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int max_vs, toggles, last_field;
    repeat (3) @(negedge clk);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset frame", int'(frame), 0);
    rst_n = 1'b1;
    repeat (150) @(negedge clk);

    // full rate, progressive, coinciding interrupts, blank 4..1
    wr(2, {10'd1, 10'd4});
    wr(1, {10'd3, 10'd3});
    wr(3, 20'b10);
    load_measure(3, 9, 3 + 2, "R2 full-rate line period");
    repeat (300) @(negedge clk);
    chk("R6 both pulses together", int'(both_seen > 0), 1);

    // distinct interrupt lines
    wr(1, {10'd7, 10'd2});
    load_measure(5, 8, 5 + 2, "R2 full-rate line period h5");
    repeat (400) @(negedge clk);

    // equal blank start and end: end wins, vsync never set
    wr(2, {10'd2, 10'd2});
    load_measure(2, 6, 2 + 2, "R2 full-rate line period h2");
    max_vs = 0;
    repeat (200) begin
      @(negedge clk);
      if (status[10]) max_vs = 1;
    end
    chk("R7 equal start/end keeps vsync low", max_vs, 0);

    // half rate, interlaced
    wr(2, {10'd0, 10'd3});
    wr(3, 20'b01);
    load_measure(2, 3, 2 * 3 + 1, "R3 half-rate line period");
    toggles = 0;
    last_field = int'(status[11]);
    repeat (400) begin
      @(negedge clk);
      if (int'(status[11]) != last_field) toggles++;
      last_field = int'(status[11]);
    end
    chk("R9 field toggles in interlace", int'(toggles >= 4), 1);

    // restart while field is 1
    while (status[11] != 1'b1) @(negedge clk);
    load_measure(4, 4, 2 * 5 + 1, "R3 half-rate line period h4");
    repeat (200) @(negedge clk);

    // switch to progressive: field clears one edge after the mode write
    while (status[11] != 1'b1) @(negedge clk);
    wr(3, 20'b00);
    @(negedge clk);
    chk("R9 field cleared in progressive", int'(status[11]), 0);
    repeat (300) @(negedge clk);

    summary();
  end
endmodule